// File: doc/BRIEF.md
# Serial Flash Auto-Increment Write Sequencer

This block sits on the host side of a serial flash. It writes a run of consecutive bytes using the flash's auto-address-increment programming scheme. Software or an upstream engine pulses `start` with a start address. It then streams data bytes through a valid/ready handshake and tags the final byte with `wr_last`. The sequencer produces every SPI transaction on its own.

A run has a fixed shape. First comes a write-enable command. Next comes the opening program transaction, which carries the opcode, the full address and the first byte. Each further byte is sent as a short program transaction that holds only the opcode and the data, because the flash advances its own address pointer. After every program transaction, the block reads the status register repeatedly until the busy flag clears. After the final byte, it sends write-disable and polls status once more, then raises `done` for one cycle. If the flash stays busy through too many consecutive status reads, the run is abandoned and `err` is raised.

The SPI side uses clock-idle-low timing. The serial clock is divided down from the system clock. Chip select is held high for a configurable minimum time between transactions.

Top module: `aai_flash_writer`

## Requirements
- R1: While `rst` is high and after its release until `start`, `spi_cs_n` is 1, `spi_sck` is 0, and `wr_ready`, `done` and `err` are 0.
- R2: The first transaction after `start` is the single byte 06h (write enable), framed alone by chip select, and it comes before any program command.
- R3: The first program transaction is 5 bytes: AFh, then the `ADDR_W`-bit start address most significant byte first, then the first data byte. Every byte is shifted MSB first.
- R4: Each later data byte is sent as a 2-byte transaction, AFh then the data byte, with no address. The bytes of a run land at consecutive addresses starting at `start_addr`.
- R5: After each program or write-disable transaction, the block issues status reads. Each read is a 2-byte transaction: 05h, then one byte clocked in from `spi_miso`, in which bit 0 set means busy. No other transaction is issued until a read returns bit 0 clear.
- R6: Once the byte tagged `wr_last` has been programmed and polled idle, the block sends the single byte 04h (write disable). It then polls until idle and pulses `done` high for exactly one cycle.
- R7: SPI mode 0 is used. `spi_sck` is 0 whenever `spi_cs_n` is high or changes. `spi_mosi` does not change while `spi_sck` is high.
- R8: Between any two transactions, `spi_cs_n` stays high for at least `CS_GAP` consecutive clock cycles.
- R9: When `POLL_LIMIT` consecutive status reads all return busy, `err` rises and the run ends with `spi_cs_n` high and no `done`. `err` then stays high until the next accepted `start`, which clears it.
- R10: `wr_ready` is high only while the block waits for the next data byte with `spi_cs_n` high. A byte is consumed on a cycle where `wr_valid` and `wr_ready` are both high.
- R11: A `start` pulse while a run is in progress is ignored. The run continues with its original address and sends no second write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (sampled only when idle) |
| start_addr | input | ADDR_W | Flash address of the first byte |
| wr_valid | input | 1 | Data byte offered |
| wr_data | input | 8 | Data byte |
| wr_last | input | 1 | Marks the final byte of the run |
| wr_ready | output | 1 | Sequencer accepts a data byte |
| done | output | 1 | One-cycle pulse when a run completes |
| err | output | 1 | Busy-poll timeout, held until next start |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest condition to reach from the ports is the poll timeout: the flash model has to report busy on every read until exactly `POLL_LIMIT` reads have gone by. The bench's behavioural flash therefore has a stuck-busy mode, and the bench confirms that the abort comes on the right read count and that `err` persists. In normal runs the model draws a random busy length of zero to three reads for each programmed byte. This drives the poll loop through a mix of immediate-idle and repeated-busy paths, while random gaps on the data stream leave the sequencer waiting in its ready state for varied lengths of time.

// File: rtl/aai_writer_pkg.sv
package aai_writer_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_AAI  = 8'hAF;

    typedef enum logic [2:0] {
        TX_WREN,
        TX_PROG_FIRST,
        TX_PROG_NEXT,
        TX_POLL,
        TX_WRDI
    } tx_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_WAIT_DATA,
        ST_XFER
    } seq_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } wr_beat_t;

    // Number of bytes framed by one chip-select window
    function automatic int unsigned tx_len(tx_kind_e kind, int unsigned addr_bytes);
        case (kind)
            TX_PROG_FIRST: return addr_bytes + 2;
            TX_PROG_NEXT:  return 2;
            TX_POLL:       return 2;
            default:       return 1;
        endcase
    endfunction

    // Byte to shift out at position idx of a transaction
    function automatic logic [7:0] tx_byte(tx_kind_e kind, int unsigned idx,
                                           logic [31:0] addr, int unsigned addr_bytes,
                                           logic [7:0] data);
        logic [7:0] b;
        b = 8'h00;
        case (kind)
            TX_WREN: b = OP_WREN;
            TX_WRDI: b = OP_WRDI;
            TX_POLL: b = (idx == 0) ? OP_RDSR : 8'h00;
            TX_PROG_NEXT: b = (idx == 0) ? OP_AAI : data;
            TX_PROG_FIRST: begin
                if (idx == 0)
                    b = OP_AAI;
                else if (idx > addr_bytes)
                    b = data;
                else
                    b = 8'(addr >> (8 * (addr_bytes - idx)));
            end
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/aai_spi_shifter.sv
module aai_spi_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV + 1);

    logic             active_q;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic             sck_q;
    logic             done_q;
    logic             half_tick;

    assign half_tick = (div_q == DIV_W'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                active_q <= 1'b1;
                div_q    <= '0;
                bit_q    <= '0;
                sh_q     <= tx_byte;
                sck_q    <= 1'b0;
            end else if (active_q) begin
                if (half_tick) begin
                    div_q <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[6:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign sck       = sck_q;
    assign mosi      = active_q & sh_q[7];
    assign byte_done = done_q;
    assign rx_byte   = rx_q;

endmodule

// File: rtl/aai_gap_timer.sv
module aai_gap_timer #(
    parameter int GAP = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int W = (GAP < 2) ? 1 : $clog2(GAP + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= W'(GAP);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0) && !load;

endmodule

// File: rtl/aai_poll_guard.sv
module aai_poll_guard #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (bump && cnt_q != W'(LIMIT))
            cnt_q <= cnt_q + W'(1);
    end

    // the next busy read would be the LIMIT-th in a row
    assign at_limit = (cnt_q >= W'(LIMIT - 1));

endmodule

// File: rtl/aai_flash_writer.sv
module aai_flash_writer
    import aai_writer_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int CLK_DIV    = 2,
    parameter int CS_GAP     = 3,
    parameter int POLL_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              wr_last,
    output logic              wr_ready,
    output logic              done,
    output logic              err,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int unsigned ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam int unsigned MAX_LEN    = ADDR_BYTES + 2;
    localparam int          IDX_W      = $clog2(MAX_LEN);

    seq_state_e        state_q;
    tx_kind_e          cur_tx_q;
    logic [ADDR_W-1:0] addr_q;
    wr_beat_t          beat_q;
    logic              closing_q;
    logic [IDX_W-1:0]  idx_q;
    logic              go_q;
    logic              gap_ld_q;
    logic              cs_n_q;
    logic              done_q;
    logic              err_q;

    logic              sh_done;
    logic [7:0]        rx_byte;
    logic [7:0]        cur_byte;
    logic              gap_expired;
    logic              poll_at_limit;
    logic              last_byte;
    logic              xfer_end;
    logic              poll_end;
    logic              poll_busy;
    logic              poll_clr;
    logic              poll_bump;

    assign last_byte = (32'(idx_q) == tx_len(cur_tx_q, ADDR_BYTES) - 1);
    assign cur_byte  = tx_byte(cur_tx_q, 32'(idx_q), 32'(addr_q), ADDR_BYTES, beat_q.data);
    assign xfer_end  = (state_q == ST_XFER) && sh_done && last_byte;
    assign poll_end  = xfer_end && (cur_tx_q == TX_POLL);
    assign poll_busy = rx_byte[0];
    assign poll_bump = poll_end && poll_busy && !poll_at_limit;
    assign poll_clr  = ((state_q == ST_IDLE) && start) || (poll_end && !poll_busy);

    aai_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .go        (go_q),
        .tx_byte   (cur_byte),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .byte_done (sh_done),
        .rx_byte   (rx_byte)
    );

    aai_gap_timer #(.GAP(CS_GAP)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_ld_q),
        .expired (gap_expired)
    );

    aai_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .clear    (poll_clr),
        .bump     (poll_bump),
        .at_limit (poll_at_limit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_tx_q  <= TX_WREN;
            addr_q    <= '0;
            beat_q    <= '0;
            closing_q <= 1'b0;
            idx_q     <= '0;
            go_q      <= 1'b0;
            gap_ld_q  <= 1'b0;
            cs_n_q    <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            go_q     <= 1'b0;
            gap_ld_q <= 1'b0;
            done_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q    <= start_addr;
                        closing_q <= 1'b0;
                        err_q     <= 1'b0;
                        cur_tx_q  <= TX_WREN;
                        gap_ld_q  <= 1'b1;
                        state_q   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_expired) begin
                        if (cur_tx_q == TX_PROG_FIRST || cur_tx_q == TX_PROG_NEXT) begin
                            state_q <= ST_WAIT_DATA;
                        end else begin
                            cs_n_q  <= 1'b0;
                            idx_q   <= '0;
                            go_q    <= 1'b1;
                            state_q <= ST_XFER;
                        end
                    end
                end
                ST_WAIT_DATA: begin
                    if (wr_valid) begin
                        beat_q  <= '{data: wr_data, last: wr_last};
                        cs_n_q  <= 1'b0;
                        idx_q   <= '0;
                        go_q    <= 1'b1;
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (sh_done) begin
                        if (!last_byte) begin
                            idx_q <= idx_q + IDX_W'(1);
                            go_q  <= 1'b1;
                        end else begin
                            cs_n_q   <= 1'b1;
                            gap_ld_q <= 1'b1;
                            state_q  <= ST_GAP;
                            case (cur_tx_q)
                                TX_WREN:       cur_tx_q <= TX_PROG_FIRST;
                                TX_PROG_FIRST,
                                TX_PROG_NEXT:  cur_tx_q <= TX_POLL;
                                TX_WRDI: begin
                                    closing_q <= 1'b1;
                                    cur_tx_q  <= TX_POLL;
                                end
                                TX_POLL: begin
                                    if (poll_busy) begin
                                        if (poll_at_limit) begin
                                            err_q   <= 1'b1;
                                            state_q <= ST_IDLE;
                                        end
                                    end else if (closing_q) begin
                                        done_q  <= 1'b1;
                                        state_q <= ST_IDLE;
                                    end else if (beat_q.last) begin
                                        cur_tx_q <= TX_WRDI;
                                    end else begin
                                        cur_tx_q <= TX_PROG_NEXT;
                                    end
                                end
                                default: cur_tx_q <= TX_WREN;
                            endcase
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_ready = (state_q == ST_WAIT_DATA);
    assign spi_cs_n = cs_n_q;
    assign done     = done_q;
    assign err      = err_q;

endmodule

// File: rtl/aai_flash_writer_chk.sv
module aai_flash_writer_chk #(
    parameter int CS_GAP = 3
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi,
    input logic wr_ready,
    input logic done,
    input logic err
);
    localparam int W = $clog2(CS_GAP + 2);

    logic [W-1:0] hi_cnt_q;

    // consecutive cycles with chip select high, saturating at CS_GAP
    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt_q <= W'(CS_GAP);
        else if (!spi_cs_n)
            hi_cnt_q <= '0;
        else if (hi_cnt_q < W'(CS_GAP))
            hi_cnt_q <= hi_cnt_q + W'(1);
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck); // R7

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R7

    AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_cnt_q >= W'(CS_GAP))); // R8

    AST_READY_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> spi_cs_n); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        done |-> !err); // R9

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err); // R9

endmodule

bind aai_flash_writer aai_flash_writer_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .wr_ready (wr_ready),
    .done     (done),
    .err      (err)
);

// File: tb/aai_flash_writer_tb.sv
`timescale 1ns/1ps
module aai_flash_writer_tb;
    localparam int ADDR_W     = 24;
    localparam int CS_GAP     = 3;
    localparam int POLL_LIMIT = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              wr_valid = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              wr_last = 1'b0;
    logic              wr_ready, done, err, spi_sck, spi_cs_n, spi_mosi;
    logic              spi_miso = 1'b0;

    always #2 clk = ~clk;

    aai_flash_writer #(.ADDR_W(ADDR_W), .CLK_DIV(2), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
        .done(done), .err(err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural flash ----------------
    logic [7:0] mem [logic [23:0]];
    logic [7:0] rxb [0:7];
    logic [7:0] sh, stat;
    logic [23:0] ptr, exp_addr;
    int nb, bitcnt, busy_left, exp_polls;
    bit in_tx, wel, aai, need_poll, stuck;
    int n_wren, n_first, n_next, n_wrdi, n_poll;
    int bad_seq, bad_wel, bad_addr, mode_bad, gap_bad, ready_bad, done_cnt;

    task automatic arm_busy();
        int bl;
        bl = stuck ? 0 : int'($urandom_range(0, 3));
        busy_left = bl;
        exp_polls += bl + 1;
        need_poll = 1;
    endtask

    task automatic decode();
        if (nb == 0 || bitcnt != nb * 8) begin bad_seq++; return; end
        if (rxb[0] != 8'h05 && need_poll) bad_seq++;
        case (rxb[0])
            8'h06: if (nb != 1) bad_seq++; else begin wel = 1; n_wren++; end
            8'hAF: begin
                if (!wel) bad_wel++;
                if (!aai) begin
                    if (nb != 5) bad_seq++;
                    else begin
                        ptr = {rxb[1], rxb[2], rxb[3]};
                        if (ptr != exp_addr) bad_addr++;
                        mem[ptr] = rxb[4]; ptr++; aai = 1; n_first++; arm_busy();
                    end
                end else begin
                    if (nb != 2) bad_seq++;
                    else begin mem[ptr] = rxb[1]; ptr++; n_next++; arm_busy(); end
                end
            end
            8'h04: if (nb != 1) bad_seq++; else begin wel = 0; aai = 0; n_wrdi++; arm_busy(); end
            8'h05: if (nb != 2) bad_seq++;
                   else begin
                       n_poll++;
                       if (stat[0]) begin if (busy_left > 0) busy_left--; end
                       else need_poll = 0;
                   end
            default: bad_seq++;
        endcase
    endtask

    always @(negedge spi_cs_n) begin
        if (spi_sck === 1'b1) mode_bad++;
        in_tx = 1; nb = 0; bitcnt = 0; spi_miso = 1'b0;
    end

    always @(posedge spi_sck) if (in_tx) begin
        sh = {sh[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
            if (nb < 8) rxb[nb] = sh;
            nb++;
        end
    end

    always @(negedge spi_sck) if (in_tx && nb >= 1 && rxb[0] == 8'h05 && bitcnt >= 8 && bitcnt < 16) begin
        if (bitcnt == 8) stat = {6'b0, wel, (stuck || busy_left > 0)};
        spi_miso = stat[15 - bitcnt];
    end

    always @(posedge spi_cs_n) if (in_tx) begin
        in_tx = 0;
        if (spi_sck === 1'b1) mode_bad++;
        decode();
    end

    // ---------------- port monitors ----------------
    int hi_cnt = 1000;
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) if (!rst) begin
        if (spi_cs_n) hi_cnt++;
        else begin
            if (prev_cs && hi_cnt < CS_GAP) gap_bad++;
            hi_cnt = 0;
        end
        if (spi_sck && prev_sck && spi_mosi !== prev_mosi) mode_bad++;
        if (spi_cs_n && spi_sck) mode_bad++;
        if (wr_ready && !spi_cs_n) ready_bad++;
        if (done) done_cnt++;
        prev_cs = spi_cs_n; prev_sck = spi_sck; prev_mosi = spi_mosi;
    end

    task automatic clear_model();
        mem.delete();
        wel = 0; aai = 0; need_poll = 0; stuck = 0; busy_left = 0; exp_polls = 0;
        n_wren = 0; n_first = 0; n_next = 0; n_wrdi = 0; n_poll = 0;
        bad_seq = 0; bad_wel = 0; bad_addr = 0; done_cnt = 0;
    endtask

    task automatic send_byte(logic [7:0] d, bit last);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_last = last;
        do @(negedge clk); while (!wr_ready);
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic pulse_start(logic [23:0] a);
        @(negedge clk);
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        int t;
        t = 0;
        while (done_cnt == 0 && !err && t < 40000) begin @(negedge clk); t++; end
        repeat (5) @(negedge clk);
    endtask

    task automatic run_burst(logic [23:0] a, int n, bit inject);
        logic [7:0] dat [0:15];
        int mism;
        clear_model();
        exp_addr = a;
        for (int i = 0; i < n; i++) dat[i] = 8'($urandom);
        pulse_start(a);
        chk(err == 1'b0, "R9", "err cleared by start", int'(err), 0);
        for (int i = 0; i < n; i++) begin
            send_byte(dat[i], i == n - 1);
            if (inject && i == 0) pulse_start(a ^ 24'h00F0F0); // R11 stray start
        end
        wait_end();
        mism = 0;
        for (int i = 0; i < n; i++)
            if (mem[24'(a + 24'(i))] !== dat[i]) mism++;
        chk(n_wren == 1 && bad_wel == 0, "R2", "write enable before program", n_wren, 1);
        chk(n_first == 1 && bad_addr == 0, inject ? "R11" : "R3", "addressed program count", n_first, 1);
        chk(n_next == n - 1, "R4", "data-only program count", n_next, n - 1);
        chk(mism == 0, "R4", "bytes at consecutive addresses", mism, 0);
        chk(n_poll == exp_polls && bad_seq == 0, "R5", "status polls", n_poll, exp_polls);
        chk(n_wrdi == 1, "R6", "write disable count", n_wrdi, 1);
        chk(done_cnt == 1 && err == 1'b0, "R6", "done pulses", done_cnt, 1);
        chk(mode_bad == 0, "R7", "mode 0 violations", mode_bad, 0);
        chk(gap_bad == 0, "R8", "chip select gap violations", gap_bad, 0);
        chk(ready_bad == 0, "R10", "ready with cs low", ready_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        mode_bad = 0; gap_bad = 0; ready_bad = 0;
        clear_model();
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && wr_ready == 1'b0 && done == 1'b0 && err == 1'b0,
            "R1", "outputs in reset", int'({spi_cs_n, spi_sck, wr_ready, done, err}), 16);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && wr_ready == 1'b0,
            "R1", "idle after reset", int'({spi_cs_n, spi_sck, wr_ready}), 4);

        // directed corners
        run_burst(24'h000000, 1, 0);
        run_burst(24'h012345, 2, 0);
        run_burst(24'hFFFFF8, 5, 0);
        // random runs
        for (int r = 0; r < 6; r++)
            run_burst(24'($urandom), int'($urandom_range(1, 12)), 0);
        // R11: stray start mid-run
        run_burst(24'h00A5C0, 4, 1);

        // R9: poll timeout with a stuck-busy flash
        clear_model();
        exp_addr = 24'h000100;
        stuck = 1;
        pulse_start(24'h000100);
        send_byte(8'h3C, 1'b1);
        wait_end();
        chk(err == 1'b1, "R9", "err after stuck busy", int'(err), 1);
        chk(n_poll == POLL_LIMIT, "R9", "polls before abort", n_poll, POLL_LIMIT);
        chk(done_cnt == 0 && spi_cs_n == 1'b1, "R9", "no done, cs high", done_cnt, 0);
        repeat (30) @(negedge clk);
        chk(err == 1'b1 && n_poll == POLL_LIMIT && n_wrdi == 0, "R9", "err held, bus quiet", int'(err), 1);

        // recovery run clears err
        run_burst(24'h3000F0, 3, 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule